// File: doc/BRIEF.md
# Clock Mode Switch Controller

This block decides which clock drives the system and sequences every change between the main oscillator, the PLL output and the low-speed sub oscillator. It also handles the PLL-stop low-power state, in which both the main oscillator and the PLL are switched off. A one-cycle request strobe carries the wanted mode and a 2-bit wait code. The controller then drives enables for the main oscillator and the PLL and a select code to an external glitch-free clock mux. It delays the select change until the new source has had time to settle.

All timing runs on the oscillation clock. Entering the PLL from main-clock operation always costs a fixed settling count. Leaving sub-clock operation or PLL-stop costs a single count, chosen by the wait code, that covers main-oscillator and PLL settling together. While a switch is in flight, a busy flag is high and any further request is dropped. Two status bits tell software which clock is really in use, so it can confirm that a switch has finished.

Top module: `clk_mode_switch`

## Requirements
- R1: After a synchronous reset the block is in main-clock operation: osc_en=1, pll_en=0, clk_sel=2'b00, stat_main=1, stat_sub=0, busy=0.
- R2: A request for mode 2'b01 (PLL) made in main-clock operation sets pll_en at once. It keeps clk_sel=2'b00 for exactly 2^PLL_LOG2 cycles after the accepting edge and then selects clk_sel=2'b01.
- R3: A request for mode 2'b10 (sub) from main or PLL operation takes effect on the accepting edge with no wait: clk_sel=2'b10 and both osc_en and pll_en low.
- R4: Leaving sub-clock operation toward PLL (mode 2'b01) waits for a count set by wait_sel: 2'b00=2^WS0_LOG2, 2'b01=2^WS1_LOG2, 2'b10=2^WS2_LOG2, 2'b11=2^WS3_LOG2 cycles. Any length shorter than 2^PLL_LOG2 is raised to 2^PLL_LOG2. Both enables are high during the wait, and the sub clock stays selected until it ends.
- R5: Leaving sub-clock operation toward main (mode 2'b00) waits for the wait_sel count with no raise. pll_en stays low throughout.
- R6: A request for mode 2'b11 (PLL-stop) from main or PLL operation drops osc_en and pll_en on the accepting edge. A later request for main or PLL wakes the block through the same wait rule as R4/R5, with the mux parked on clk_sel=2'b00.
- R7: stat_main is high exactly when clk_sel=2'b00 and stat_sub exactly when clk_sel=2'b10. Both are low while the PLL is selected.
- R8: busy is high from the edge that accepts a waited switch until the edge on which clk_sel shows the new source, and low otherwise.
- R9: A request that arrives while busy is high has no effect: neither the target nor the remaining wait changes.
- R10: A request for main (2'b00) in PLL operation selects the main clock on the accepting edge with no wait, and pll_en drops.
- R11: A request for the mode already in use changes nothing and does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillation clock |
| rst | input | 1 | Synchronous active-high reset |
| req_en | input | 1 | One-cycle strobe for a mode request |
| req_mode | input | 2 | Wanted mode: 00 main, 01 PLL, 10 sub, 11 PLL-stop |
| wait_sel | input | 2 | Settling-wait code used when leaving sub or PLL-stop |
| osc_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | PLL enable |
| clk_sel | output | 2 | Clock mux select: 00 main, 01 PLL, 10 sub |
| stat_main | output | 1 | Main clock in use |
| stat_sub | output | 1 | Sub clock in use |
| busy | output | 1 | Switch in progress |

## Verification
A corrupted state register or target flag appears on the select and enable outputs on the very next edge, because every output is registered straight from the next state. A miscounted or misloaded wait timer shows up only when the switch completes, as a select change one or more cycles early or late. For that reason the directed tests sample the cycle before and the cycle of every expected completion. A target flag that was wrongly overwritten by a dropped request is exposed when the wait ends and the wrong source is selected.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [1:0] {
    MODE_MAIN = 2'b00,
    MODE_PLL  = 2'b01,
    MODE_SUB  = 2'b10,
    MODE_STOP = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_MAIN, ST_WAIT_PLL, ST_PLL, ST_SUB, ST_WAIT_OSC, ST_PLLSTOP
  } state_e;

  localparam logic [1:0] SEL_MAIN = 2'b00;
  localparam logic [1:0] SEL_PLL  = 2'b01;
  localparam logic [1:0] SEL_SUB  = 2'b10;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/clksw_wait_len.sv
module clksw_wait_len #(
  parameter int PLL_LOG2 = 14,
  parameter int WS0_LOG2 = 10,
  parameter int WS1_LOG2 = 13,
  parameter int WS2_LOG2 = 15,
  parameter int WS3_LOG2 = 17,
  parameter int CW       = 18
) (
  input  logic          fixed_pll,
  input  logic          need_pll,
  input  logic [1:0]    wait_sel,
  output logic [CW-1:0] len_m1
);
  int sel_lg;
  int use_lg;

  always_comb begin
    case (wait_sel)
      2'b00:   sel_lg = WS0_LOG2;
      2'b01:   sel_lg = WS1_LOG2;
      2'b10:   sel_lg = WS2_LOG2;
      default: sel_lg = WS3_LOG2;
    endcase
    if (fixed_pll)
      use_lg = PLL_LOG2;
    else if (need_pll)
      use_lg = clksw_pkg::imax(sel_lg, PLL_LOG2);
    else
      use_lg = sel_lg;
    len_m1 = ({{(CW-1){1'b0}}, 1'b1} << use_lg) - {{(CW-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/clksw_timer.sv
module clksw_timer #(
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (run && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/clksw_outreg.sv
module clksw_outreg
  import clksw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  state_e     state_d,
  input  logic       tgt_pll_d,
  input  logic       from_sub_d,
  output logic       osc_en,
  output logic       pll_en,
  output logic [1:0] clk_sel,
  output logic       stat_main,
  output logic       stat_sub,
  output logic       busy
);
  logic       osc_n, pll_n, busy_n;
  logic [1:0] sel_n;

  always_comb begin
    osc_n  = 1'b1;
    pll_n  = 1'b0;
    sel_n  = SEL_MAIN;
    busy_n = 1'b0;
    case (state_d)
      ST_MAIN: ;
      ST_WAIT_PLL: begin
        pll_n  = 1'b1;
        busy_n = 1'b1;
      end
      ST_PLL: begin
        pll_n = 1'b1;
        sel_n = SEL_PLL;
      end
      ST_SUB: begin
        osc_n = 1'b0;
        sel_n = SEL_SUB;
      end
      ST_WAIT_OSC: begin
        pll_n  = tgt_pll_d;
        sel_n  = from_sub_d ? SEL_SUB : SEL_MAIN;
        busy_n = 1'b1;
      end
      ST_PLLSTOP: osc_n = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_en    <= 1'b1;
      pll_en    <= 1'b0;
      clk_sel   <= SEL_MAIN;
      stat_main <= 1'b1;
      stat_sub  <= 1'b0;
      busy      <= 1'b0;
    end else begin
      osc_en    <= osc_n;
      pll_en    <= pll_n;
      clk_sel   <= sel_n;
      stat_main <= (sel_n == SEL_MAIN);
      stat_sub  <= (sel_n == SEL_SUB);
      busy      <= busy_n;
    end
  end
endmodule

// File: rtl/clk_mode_switch.sv
module clk_mode_switch
  import clksw_pkg::*;
#(
  parameter int PLL_LOG2 = 14,
  parameter int WS0_LOG2 = 10,
  parameter int WS1_LOG2 = 13,
  parameter int WS2_LOG2 = 15,
  parameter int WS3_LOG2 = 17
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_en,
  input  logic [1:0] req_mode,
  input  logic [1:0] wait_sel,
  output logic       osc_en,
  output logic       pll_en,
  output logic [1:0] clk_sel,
  output logic       stat_main,
  output logic       stat_sub,
  output logic       busy
);
  localparam int MAXL = imax(imax(imax(WS0_LOG2, WS1_LOG2), imax(WS2_LOG2, WS3_LOG2)), PLL_LOG2);
  localparam int CW   = MAXL + 1;

  state_e        state_q, state_d;
  logic          tgt_pll_q, tgt_pll_d;
  logic          from_sub_q, from_sub_d;
  logic          load, done, in_wait;
  logic [CW-1:0] len_m1;
  mode_e         rq;

  assign rq      = mode_e'(req_mode);
  assign in_wait = (state_q == ST_WAIT_PLL) || (state_q == ST_WAIT_OSC);

  clksw_wait_len #(
    .PLL_LOG2(PLL_LOG2), .WS0_LOG2(WS0_LOG2), .WS1_LOG2(WS1_LOG2),
    .WS2_LOG2(WS2_LOG2), .WS3_LOG2(WS3_LOG2), .CW(CW)
  ) u_len (
    .fixed_pll (state_q == ST_MAIN),
    .need_pll  (rq == MODE_PLL),
    .wait_sel  (wait_sel),
    .len_m1    (len_m1)
  );

  clksw_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (len_m1),
    .run      (in_wait),
    .done     (done)
  );

  always_comb begin
    state_d    = state_q;
    tgt_pll_d  = tgt_pll_q;
    from_sub_d = from_sub_q;
    load       = 1'b0;
    case (state_q)
      ST_MAIN: if (req_en) begin
        case (rq)
          MODE_PLL: begin
            state_d   = ST_WAIT_PLL;
            tgt_pll_d = 1'b1;
            load      = 1'b1;
          end
          MODE_SUB:  state_d = ST_SUB;
          MODE_STOP: state_d = ST_PLLSTOP;
          default: ;
        endcase
      end
      ST_PLL: if (req_en) begin
        case (rq)
          MODE_MAIN: state_d = ST_MAIN;
          MODE_SUB:  state_d = ST_SUB;
          MODE_STOP: state_d = ST_PLLSTOP;
          default: ;
        endcase
      end
      ST_SUB: if (req_en) begin
        case (rq)
          MODE_MAIN, MODE_PLL: begin
            state_d    = ST_WAIT_OSC;
            tgt_pll_d  = (rq == MODE_PLL);
            from_sub_d = 1'b1;
            load       = 1'b1;
          end
          MODE_STOP: state_d = ST_PLLSTOP;
          default: ;
        endcase
      end
      ST_PLLSTOP: if (req_en) begin
        case (rq)
          MODE_MAIN, MODE_PLL: begin
            state_d    = ST_WAIT_OSC;
            tgt_pll_d  = (rq == MODE_PLL);
            from_sub_d = 1'b0;
            load       = 1'b1;
          end
          MODE_SUB: state_d = ST_SUB;
          default: ;
        endcase
      end
      ST_WAIT_PLL: if (done) state_d = ST_PLL;
      ST_WAIT_OSC: if (done) state_d = tgt_pll_q ? ST_PLL : ST_MAIN;
      default: state_d = ST_MAIN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_MAIN;
      tgt_pll_q  <= 1'b0;
      from_sub_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      tgt_pll_q  <= tgt_pll_d;
      from_sub_q <= from_sub_d;
    end
  end

  clksw_outreg u_out (
    .clk        (clk),
    .rst        (rst),
    .state_d    (state_d),
    .tgt_pll_d  (tgt_pll_d),
    .from_sub_d (from_sub_d),
    .osc_en     (osc_en),
    .pll_en     (pll_en),
    .clk_sel    (clk_sel),
    .stat_main  (stat_main),
    .stat_sub   (stat_sub),
    .busy       (busy)
  );
endmodule

// File: rtl/clk_mode_switch_chk.sv
module clk_mode_switch_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_en,
  input logic [1:0] req_mode,
  input logic [1:0] wait_sel,
  input logic       osc_en,
  input logic       pll_en,
  input logic [1:0] clk_sel,
  input logic       stat_main,
  input logic       stat_sub,
  input logic       busy
);
  AST_PLL_SEL_HAS_SRC: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == 2'b01) |-> (pll_en && osc_en)); // R2

  AST_SUB_OSC_OFF: assert property (@(posedge clk) disable iff (rst)
    (stat_sub && !busy) |-> (!osc_en && !pll_en)); // R3

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(stat_main && stat_sub)); // R7

  AST_SUB_STATUS: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == 2'b10) |-> stat_sub); // R7

  AST_WAIT_OSC_ON: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> osc_en); // R8

  AST_BUSY_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(clk_sel)); // R9
endmodule

bind clk_mode_switch clk_mode_switch_chk u_chk (.*);

// File: tb/clk_mode_switch_bench.sv
module clk_mode_switch_bench;
  localparam int PLL_LOG2 = 5;
  localparam int WS0 = 3, WS1 = 4, WS2 = 6, WS3 = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_en = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic [1:0] wait_sel = 2'b00;
  logic osc_en, pll_en, stat_main, stat_sub, busy;
  logic [1:0] clk_sel;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // {busy, stat_sub, stat_main, pll_en, osc_en, clk_sel}
  localparam logic [6:0] P_MAIN  = 7'b0_0_1_0_1_00;
  localparam logic [6:0] P_WPLL  = 7'b1_0_1_1_1_00;
  localparam logic [6:0] P_PLL   = 7'b0_0_0_1_1_01;
  localparam logic [6:0] P_SUB   = 7'b0_1_0_0_0_10;
  localparam logic [6:0] P_STOP  = 7'b0_0_1_0_0_00;

  always #5 clk = ~clk;

  clk_mode_switch #(
    .PLL_LOG2(PLL_LOG2), .WS0_LOG2(WS0), .WS1_LOG2(WS1),
    .WS2_LOG2(WS2), .WS3_LOG2(WS3)
  ) u_clk_mode_switch (
    .clk(clk), .rst(rst), .req_en(req_en), .req_mode(req_mode),
    .wait_sel(wait_sel), .osc_en(osc_en), .pll_en(pll_en),
    .clk_sel(clk_sel), .stat_main(stat_main), .stat_sub(stat_sub),
    .busy(busy)
  );

  function automatic logic [6:0] outs();
    return {busy, stat_sub, stat_main, pll_en, osc_en, clk_sel};
  endfunction

  task automatic chk(input string tag, input logic [6:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, outs(), exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic issue(input logic [1:0] m, input logic [1:0] ws);
    @(negedge clk);
    req_en = 1'b1; req_mode = m; wait_sel = ws;
    @(posedge clk);
    #1;
    req_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    edges(3);
    chk("R1 reset state", P_MAIN);
    @(negedge clk);
    rst = 1'b0;
    edges(1);
    chk("R1 after reset release", P_MAIN);
  endtask

  task automatic t_same_mode();
    issue(2'b00, 2'b00);
    chk("R11 same-mode request", P_MAIN);
  endtask

  task automatic t_main_to_pll();
    int n = 1 << PLL_LOG2;
    issue(2'b01, 2'b11);
    chk("R2/R8 entering PLL wait", P_WPLL);
    edges(n - 1);
    chk("R2 last wait cycle still main", P_WPLL);
    edges(1);
    chk("R2/R7 PLL selected", P_PLL);
  endtask

  task automatic t_pll_to_main();
    issue(2'b00, 2'b00);
    chk("R10 PLL to main immediate", P_MAIN);
  endtask

  task automatic t_busy_ignore();
    int n = 1 << PLL_LOG2;
    issue(2'b01, 2'b00);
    edges(2);
    issue(2'b10, 2'b00);
    chk("R9 request during wait dropped", P_WPLL);
    edges(n - 4);
    chk("R9 wait length kept", P_WPLL);
    edges(1);
    chk("R9 original target reached", P_PLL);
  endtask

  task automatic t_to_sub(input string tag);
    issue(2'b10, 2'b00);
    chk(tag, P_SUB);
  endtask

  task automatic t_wake(input string tag, input bit from_sub, input bit to_pll,
                        input logic [1:0] ws, input int n);
    logic [6:0] pw;
    pw = {1'b1, from_sub, !from_sub, to_pll, 1'b1, from_sub ? 2'b10 : 2'b00};
    issue(to_pll ? 2'b01 : 2'b00, ws);
    chk({tag, " wait entered"}, pw);
    edges(n - 1);
    chk({tag, " last wait cycle"}, pw);
    edges(1);
    chk({tag, " done"}, to_pll ? P_PLL : P_MAIN);
  endtask

  task automatic t_stop();
    issue(2'b11, 2'b00);
    chk("R6 PLL-stop entered", P_STOP);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_same_mode();
    t_main_to_pll();
    t_pll_to_main();
    t_busy_ignore();
    t_to_sub("R3 PLL to sub");
    t_wake("R4 code00 raised", 1'b1, 1'b1, 2'b00, 1 << PLL_LOG2);
    t_to_sub("R3 PLL to sub again");
    t_wake("R4 code10", 1'b1, 1'b1, 2'b10, 1 << WS2);
    t_to_sub("R3 PLL to sub third");
    t_wake("R4 code11", 1'b1, 1'b1, 2'b11, 1 << WS3);
    t_to_sub("R3 PLL to sub fourth");
    t_wake("R5 sub to main code00", 1'b1, 1'b0, 2'b00, 1 << WS0);
    t_to_sub("R3 main to sub");
    t_wake("R5 sub to main code01", 1'b1, 1'b0, 2'b01, 1 << WS1);
    t_stop();
    t_wake("R6 wake to PLL code01", 1'b0, 1'b1, 2'b01, 1 << PLL_LOG2);
    t_stop();
    t_wake("R6 wake to main code00", 1'b0, 1'b0, 2'b00, 1 << WS0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule